// File: doc/BRIEF.md
# Timing Margin Sweep Controller

This block automates a timing-margin search on a bus. A separate violation detector watches the bus against a programmable setup window and a programmable hold window, measured in 500 ps ticks. The detector raises a trigger pulse when the bus breaks either window. The controller drives both window settings. It starts one acquisition at a time with an arm pulse. It counts qualifying strobe edges to decide when an acquisition has run long enough without a trigger.

A start pulse latches the two specification values and a mode bit. The mode bit selects whether the setup window or the hold window is swept. The first acquisition uses both specification values exactly, which confirms that the specification itself is met. After each clean acquisition the swept window grows by one tick, and the other window stays at its specification. The sweep stops at the first acquisition that triggers. The reported margin is the widest window that never triggered minus the specification, so it is a lower bound on the real slack. For example, a 3.5 ns (7 tick) specification that first triggers at 5 ns (10 ticks) reports 2 ticks, which is 1 ns.

Two flags mark the special outcomes. The fail flag means the specification acquisition itself triggered. The saturated flag means the window reached its upper limit without any trigger.

Top module: `margin_sweep_ctrl`

## Requirements
- R1: The first acquisition after an accepted start presents both windows equal to the specification values captured at that start. `sweep_hold`=0 sweeps setup and `sweep_hold`=1 sweeps hold.
- R2: `arm` is high for exactly one cycle per acquisition. Each acquisition after the first presents a swept window exactly one tick wider than the one before.
- R3: The window that is not swept equals its captured specification in every acquisition of the sweep.
- R4: An acquisition passes when `strobe` has been seen high on `max(run_len,1)` cycles after its arm cycle, with no trigger. A trigger during the acquisition ends the sweep. A trigger in the same cycle as the final strobe counts as a trigger.
- R5: When a later acquisition triggers, `margin` equals the last passing swept window minus the swept specification, and both flags are low.
- R6: A trigger in the first acquisition sets `spec_fail`, clears `saturated` and reports `margin` = 0.
- R7: A pass with the swept window at or above `MAX_WIN` ends the sweep with `saturated` = 1 and `margin` = window − specification.
- R8: `done` rises when a sweep ends and stays high until the next start. `margin`, `spec_fail` and `saturated` stay stable while `done` is high, even if `trig` or `strobe` toggle.
- R9: A start pulse during a running sweep is ignored, and the sweep's result is unchanged.
- R10: After reset, `done`, `arm`, both flags, `margin` and both window outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted when idle or done) |
| sweep_hold | input | 1 | 0 sweeps setup, 1 sweeps hold |
| spec_setup | input | WIN_W | Setup specification in ticks |
| spec_hold | input | WIN_W | Hold specification in ticks |
| run_len | input | RUN_W | Strobe edges per acquisition (0 acts as 1) |
| strobe | input | 1 | One cycle per observed strobe edge |
| trig | input | 1 | Violation pulse from the detector |
| win_setup | output | WIN_W | Setup window applied to the detector |
| win_hold | output | WIN_W | Hold window applied to the detector |
| arm | output | 1 | One-cycle pulse that starts an acquisition |
| done | output | 1 | Sweep finished; result valid |
| spec_fail | output | 1 | Specification acquisition triggered |
| saturated | output | 1 | Window limit reached without a trigger |
| margin | output | WIN_W | Measured margin in ticks |

## Verification
On every cycle the checker confirms several properties against its own copy of the captured specification. The arm pulse is one cycle wide. The first acquisition sits at the specification, each later one is exactly one tick wider, and the fixed window never moves. The result and `done` stay stable while `done` is high, and the two flags never appear together. Only the bench scenarios can show that the right number of acquisitions ran and that a trigger coinciding with the last strobe wins. They also show that a zero run length behaves as one, that a start in mid-sweep leaves the result unchanged, and that the margin value matches the model of the device's real window for pass, fail and saturated sweeps.

// File: rtl/margin_sweep_pkg.sv
package margin_sweep_pkg;

    localparam int WIN_W = 8;

    typedef logic [WIN_W-1:0] tick_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } sweep_state_e;

    typedef struct packed {
        logic  hold_mode;
        tick_t setup;
        tick_t hold;
    } sweep_cfg_t;

    typedef struct packed {
        logic  spec_fail;
        logic  saturated;
        tick_t margin;
    } sweep_res_t;

    function automatic tick_t swept_spec(input sweep_cfg_t c);
        return c.hold_mode ? c.hold : c.setup;
    endfunction

    function automatic tick_t gap_after_pass(input tick_t last_ok, input tick_t spec);
        return last_ok - spec;
    endfunction

endpackage

// File: rtl/msw_acq_counter.sv
module msw_acq_counter #(
    parameter int RUN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             count_en,
    input  logic [RUN_W-1:0] run_len,
    output logic             hit
);
    localparam int EXT_W = RUN_W + 1;

    logic [RUN_W-1:0] seen_q;
    logic [EXT_W-1:0] need;
    logic [EXT_W-1:0] seen_next;

    always_comb begin
        need      = (run_len == '0) ? EXT_W'(1) : {1'b0, run_len};
        seen_next = {1'b0, seen_q} + EXT_W'(1);
        hit       = count_en && (seen_next >= need);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen_q <= '0;
        end else if (count_en && !hit) begin
            seen_q <= seen_next[RUN_W-1:0];
        end
    end
endmodule

// File: rtl/msw_window.sv
module msw_window
    import margin_sweep_pkg::*;
#(
    parameter int MAX_WIN = 60
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  tick_t load_val,
    input  logic  step,
    output tick_t win,
    output logic  at_limit
);
    localparam tick_t LIMIT = tick_t'(MAX_WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (load) begin
            win <= load_val;
        end else if (step) begin
            win <= win + tick_t'(1);
        end
    end

    assign at_limit = (win >= LIMIT);
endmodule

// File: rtl/msw_fsm.sv
module msw_fsm
    import margin_sweep_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sweep_hold,
    input  tick_t        spec_setup,
    input  tick_t        spec_hold,
    input  logic         trig,
    input  logic         acq_hit,
    input  logic         at_limit,
    input  tick_t        swept,
    output sweep_state_e state_q,
    output sweep_cfg_t   cfg_q,
    output sweep_res_t   res_q,
    output logic         win_load,
    output tick_t        win_load_val,
    output logic         win_step,
    output logic         cnt_clear,
    output logic         running
);
    logic  first_q;
    logic  idle_like;
    tick_t spec_sw;

    always_comb begin
        idle_like    = (state_q == ST_IDLE) || (state_q == ST_DONE);
        running      = (state_q == ST_RUN);
        spec_sw      = swept_spec(cfg_q);
        win_load     = idle_like && start;
        win_load_val = sweep_hold ? spec_hold : spec_setup;
        win_step     = running && !trig && acq_hit && !at_limit;
        cnt_clear    = (state_q == ST_ARM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            res_q   <= '0;
            first_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        cfg_q   <= '{hold_mode: sweep_hold, setup: spec_setup, hold: spec_hold};
                        res_q   <= '0;
                        first_q <= 1'b1;
                        state_q <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (trig) begin
                        if (first_q) begin
                            res_q <= '{spec_fail: 1'b1, saturated: 1'b0, margin: '0};
                        end else begin
                            res_q <= '{spec_fail: 1'b0, saturated: 1'b0,
                                       margin: gap_after_pass(swept - tick_t'(1), spec_sw)};
                        end
                        state_q <= ST_DONE;
                    end else if (acq_hit) begin
                        if (at_limit) begin
                            res_q <= '{spec_fail: 1'b0, saturated: 1'b1,
                                       margin: gap_after_pass(swept, spec_sw)};
                            state_q <= ST_DONE;
                        end else begin
                            first_q <= 1'b0;
                            state_q <= ST_ARM;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/margin_sweep_ctrl.sv
module margin_sweep_ctrl
    import margin_sweep_pkg::*;
#(
    parameter int RUN_W   = 12,
    parameter int MAX_WIN = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sweep_hold,
    input  logic [WIN_W-1:0] spec_setup,
    input  logic [WIN_W-1:0] spec_hold,
    input  logic [RUN_W-1:0] run_len,
    input  logic             strobe,
    input  logic             trig,
    output logic [WIN_W-1:0] win_setup,
    output logic [WIN_W-1:0] win_hold,
    output logic             arm,
    output logic             done,
    output logic             spec_fail,
    output logic             saturated,
    output logic [WIN_W-1:0] margin
);
    sweep_state_e state_q;
    sweep_cfg_t   cfg_q;
    sweep_res_t   res_q;
    logic         win_load;
    tick_t        win_load_val;
    logic         win_step;
    logic         cnt_clear;
    logic         running;
    logic         acq_hit;
    logic         at_limit;
    tick_t        swept;

    msw_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sweep_hold   (sweep_hold),
        .spec_setup   (spec_setup),
        .spec_hold    (spec_hold),
        .trig         (trig),
        .acq_hit      (acq_hit),
        .at_limit     (at_limit),
        .swept        (swept),
        .state_q      (state_q),
        .cfg_q        (cfg_q),
        .res_q        (res_q),
        .win_load     (win_load),
        .win_load_val (win_load_val),
        .win_step     (win_step),
        .cnt_clear    (cnt_clear),
        .running      (running)
    );

    msw_acq_counter #(.RUN_W(RUN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (cnt_clear),
        .count_en (running && strobe),
        .run_len  (run_len),
        .hit      (acq_hit)
    );

    msw_window #(.MAX_WIN(MAX_WIN)) u_win (
        .clk      (clk),
        .rst      (rst),
        .load     (win_load),
        .load_val (win_load_val),
        .step     (win_step),
        .win      (swept),
        .at_limit (at_limit)
    );

    always_comb begin
        if (state_q == ST_IDLE) begin
            win_setup = '0;
            win_hold  = '0;
        end else if (cfg_q.hold_mode) begin
            win_setup = cfg_q.setup;
            win_hold  = swept;
        end else begin
            win_setup = swept;
            win_hold  = cfg_q.hold;
        end
        arm       = (state_q == ST_ARM);
        done      = (state_q == ST_DONE);
        spec_fail = res_q.spec_fail;
        saturated = res_q.saturated;
        margin    = res_q.margin;
    end
endmodule

// File: rtl/msw_checker.sv
module msw_checker
    import margin_sweep_pkg::*;
#(
    parameter int MAX_WIN = 60
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             sweep_hold,
    input logic [WIN_W-1:0] spec_setup,
    input logic [WIN_W-1:0] spec_hold,
    input logic [WIN_W-1:0] win_setup,
    input logic [WIN_W-1:0] win_hold,
    input logic             arm,
    input logic             done,
    input logic             spec_fail,
    input logic             saturated,
    input logic [WIN_W-1:0] margin
);
    logic  busy_c;
    logic  seen_arm_c;
    logic  mode_c;
    tick_t set_c;
    tick_t hld_c;
    tick_t last_c;
    tick_t swept_obs;
    tick_t fixed_obs;
    tick_t swept_ref;
    tick_t fixed_ref;

    always_comb begin
        swept_obs = mode_c ? win_hold : win_setup;
        fixed_obs = mode_c ? win_setup : win_hold;
        swept_ref = mode_c ? hld_c : set_c;
        fixed_ref = mode_c ? set_c : hld_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c     <= 1'b0;
            seen_arm_c <= 1'b0;
            mode_c     <= 1'b0;
            set_c      <= '0;
            hld_c      <= '0;
            last_c     <= '0;
        end else begin
            if (start && (!busy_c || done)) begin
                busy_c     <= 1'b1;
                seen_arm_c <= 1'b0;
                mode_c     <= sweep_hold;
                set_c      <= spec_setup;
                hld_c      <= spec_hold;
            end else begin
                if (busy_c && done) busy_c <= 1'b0;
                if (arm) begin
                    seen_arm_c <= 1'b1;
                    last_c     <= swept_obs;
                end
            end
        end
    end

    AST_FIRST_AT_SPEC: assert property (@(posedge clk) disable iff (rst)
        arm && !seen_arm_c |-> swept_obs == swept_ref);   // R1

    AST_ARM_SINGLE: assert property (@(posedge clk) disable iff (rst)
        arm |=> !arm);   // R2

    AST_ONE_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        arm && seen_arm_c |-> swept_obs == last_c + tick_t'(1));   // R2

    AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (rst)
        arm |-> fixed_obs == fixed_ref);   // R3

    AST_FAIL_NO_MARGIN: assert property (@(posedge clk) disable iff (rst)
        spec_fail |-> margin == '0 && !saturated);   // R6

    AST_SAT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        saturated |-> margin <= tick_t'(MAX_WIN));   // R7

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);   // R8

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        done && $past(done) |-> $stable(margin) && $stable(spec_fail) && $stable(saturated));   // R8
endmodule

bind margin_sweep_ctrl msw_checker #(.MAX_WIN(MAX_WIN)) u_chk (.*);

// File: tb/margin_sweep_ctrl_test.sv
module margin_sweep_ctrl_test;
    localparam int WW      = 8;
    localparam int RW      = 12;
    localparam int MAXW    = 60;

    typedef struct {
        int margin;
        bit fail;
        bit sat;
        int acqs;
        int tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          sweep_hold = 1'b0;
    logic [WW-1:0] spec_setup = '0;
    logic [WW-1:0] spec_hold = '0;
    logic [RW-1:0] run_len = '0;
    logic          strobe = 1'b0;
    logic          trig = 1'b0;
    logic [WW-1:0] win_setup;
    logic [WW-1:0] win_hold;
    logic          arm;
    logic          done;
    logic          spec_fail;
    logic          saturated;
    logic [WW-1:0] margin;

    int   n_checks = 0;
    int   n_fail = 0;
    int   acq_seen = 0;
    int   results_seen = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    margin_sweep_ctrl #(.RUN_W(RW), .MAX_WIN(MAXW)) uut (
        .clk(clk), .rst(rst), .start(start), .sweep_hold(sweep_hold),
        .spec_setup(spec_setup), .spec_hold(spec_hold), .run_len(run_len),
        .strobe(strobe), .trig(trig), .win_setup(win_setup), .win_hold(win_hold),
        .arm(arm), .done(done), .spec_fail(spec_fail), .saturated(saturated),
        .margin(margin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // monitor: pops the expected result when done rises
    logic done_d = 1'b0;
    always @(negedge clk) begin
        if (!rst && done && !done_d) begin
            if (sb_q.size() == 0) begin
                check("R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                results_seen++;
                check($sformatf("R5 margin s%0d", e.tag), int'(margin), e.margin);
                check($sformatf("R6 spec_fail s%0d", e.tag), int'(spec_fail), int'(e.fail));
                check($sformatf("R7 saturated s%0d", e.tag), int'(saturated), int'(e.sat));
                check($sformatf("R4 acquisitions s%0d", e.tag), acq_seen, e.acqs);
            end
        end
        done_d <= done;
    end

    // driver: model of the device is a true window 'avail'; wider windows trigger
    task automatic run_sweep(input int tag, input bit hmode, input int ss, input int sh,
                             input int rl, input int avail, input bit inject);
        exp_t e;
        int   s;
        int   guard;
        bit   first;
        int   prev;
        s = hmode ? sh : ss;
        e.tag = tag;
        if (avail < s) begin
            e.margin = 0; e.fail = 1; e.sat = 0; e.acqs = 1;
        end else if (avail >= MAXW) begin
            e.margin = MAXW - s; e.fail = 0; e.sat = 1; e.acqs = MAXW - s + 1;
        end else begin
            e.margin = avail - s; e.fail = 0; e.sat = 0; e.acqs = avail - s + 2;
        end
        sb_q.push_back(e);
        sweep_hold = hmode;
        spec_setup = WW'(ss);
        spec_hold  = WW'(sh);
        run_len    = RW'(rl);
        acq_seen   = 0;
        first      = 1'b1;
        prev       = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin
            guard++;
            if (arm) begin
                int sw;
                int fx;
                acq_seen++;
                sw = hmode ? int'(win_hold) : int'(win_setup);
                fx = hmode ? int'(win_setup) : int'(win_hold);
                if (first) check("R1 first window at spec", sw, s);
                else       check("R2 one tick step", sw, prev + 1);
                check("R3 fixed window at spec", fx, hmode ? ss : sh);
                first = 1'b0;
                prev  = sw;
                @(negedge clk);
                check("R2 arm one cycle", int'(arm), 0);
                if (sw > avail) begin
                    // R4: trigger coincides with the first (and last, rl<=1) strobe
                    strobe = 1'b1;
                    trig   = 1'b1;
                    @(negedge clk);
                    strobe = 1'b0;
                    trig   = 1'b0;
                end else begin
                    int nstr;
                    nstr = (rl == 0) ? 1 : rl;
                    for (int i = 0; i < nstr; i++) begin
                        strobe = 1'b1;
                        start  = inject && (acq_seen == 2) && (i == 0);  // R9
                        @(negedge clk);
                        strobe = 1'b0;
                        start  = 1'b0;
                        if (i != nstr - 1) @(negedge clk);
                    end
                end
            end else begin
                @(negedge clk);
            end
        end
        if (guard >= 5000) check("R4 sweep ended", 0, 1);
        @(negedge clk);
        // R8: stimulus after done must not disturb the result
        begin
            int m0;
            int f0;
            int s0;
            m0 = int'(margin); f0 = int'(spec_fail); s0 = int'(saturated);
            trig = 1'b1; strobe = 1'b1;
            repeat (3) @(negedge clk);
            trig = 1'b0; strobe = 1'b0;
            @(negedge clk);
            check("R8 done held", int'(done), 1);
            check("R8 margin stable", int'(margin), m0);
            check("R8 flags stable", int'({spec_fail, saturated}), int'({f0[0], s0[0]}));
            check("R2 no arm after done", int'(arm), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 done after reset", int'(done), 0);
        check("R10 arm after reset", int'(arm), 0);
        check("R10 flags after reset", int'({spec_fail, saturated}), 0);
        check("R10 margin after reset", int'(margin), 0);
        check("R10 windows after reset", int'({win_setup, win_hold}), 0);

        run_sweep(1, 1'b0, 7, 3, 3, 9, 1'b0);     // 3.5 ns setup, first trigger at 10 ticks
        run_sweep(2, 1'b1, 7, 3, 1, 3, 1'b0);     // hold sweep, trips right after spec
        run_sweep(3, 1'b0, 7, 3, 2, 5, 1'b0);     // R6 spec itself violated
        run_sweep(4, 1'b1, 4, 55, 2, 200, 1'b0);  // R7 saturates at limit
        run_sweep(5, 1'b0, 10, 3, 0, 12, 1'b0);   // R4 zero run length acts as one
        run_sweep(6, 1'b0, 4, 6, 2, 6, 1'b1);     // R9 start mid-sweep ignored
        check("R5 all results seen", results_seen, 6);
        report();
    end

    initial begin
        repeat (150000) @(negedge clk);
        check("watchdog expired", 0, 1);
        report();
    end
endmodule